// File: doc/BRIEF.md
# In-Lane Byte Shuffle Unit

This block permutes the bytes of a 256-bit data word under the control of a 256-bit control word. Each control byte decides what appears at the output byte in the same position. If its top bit is set, that output byte is zero. Otherwise its low four bits name one of the sixteen data bytes in the same 128-bit lane. Bytes never move between lanes.

A two-bit mode picks how the upper half of the result is formed:
- The upper lane can be shuffled the same way as the lower lane.
- It can be forced to zero.
- It can keep what the result register already held. This is the destructive 128-bit form, where the result register acts as the destination.

Results are registered. A request accepted on one clock appears on the next clock together with its valid flag.

Top module: `lane_byte_permuter`

## Requirements
- R1: After a synchronous active-high reset, `outValid` is 0 and `outData` is all zeros.
- R2: `outValid` equals the value `inValid` had at the previous rising clock edge.
- R3: An output byte is 0x00 whenever bit 7 of its control byte is 1, in every mode and in every lane that is shuffled.
- R4: When bit 7 of a control byte is 0, bits 3:0 of that byte give an index k. The output byte is then data byte k of the same lane, where data byte k of lane L occupies bits (L*128 + 8k + 7) down to (L*128 + 8k).
- R5: Bits 6:4 of a control byte have no effect on the output.
- R6: With `inMode` = 2'b10 or 2'b11, bits 255:128 of the result are the shuffle of data bytes 16..31 under control bytes 16..31. No lower-lane data byte ever appears there.
- R7: With `inMode` = 2'b00, bits 255:128 of the result keep the value `outData` held before the update.
- R8: With `inMode` = 2'b01, bits 255:128 of the result are zero.
- R9: In every mode, bits 127:0 of the result are the shuffle of data bytes 0..15 under control bytes 0..15.
- R10: On a clock where `inValid` is 0, `outData` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Request strobe |
| inMode | input | 2 | 00 destructive 128-bit, 01 zeroing 128-bit, 10/11 full 256-bit |
| inData | input | 256 | Data bytes to be permuted |
| inCtrl | input | 256 | One control byte per output byte |
| outValid | output | 1 | Result valid, one clock after the request |
| outData | output | 256 | Registered result |

## Verification
There are two ways internal state can go wrong in this block:
- A wrong held upper half. This shows up on the very first result after a destructive 128-bit request, when bits 255:128 differ from what `outData` showed one clock earlier.
- Any slip in index decoding or lane selection. This corrupts a byte in the same result the request produces, one clock after the request.

The reference model is compared against the design on every clock. The held upper half is compared too, so a stale or leaked byte is caught at the clock it first appears. Distinct data in each lane makes any cross-lane pick show up as a mismatch straight away.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

  typedef enum logic [1:0] {
    MODE_KEEP128  = 2'b00,
    MODE_ZERO128  = 2'b01,
    MODE_FULL256  = 2'b10,
    MODE_FULL256B = 2'b11
  } lbpMode_e;

  typedef struct packed {
    logic load;
    logic upperKeep;
    logic upperZero;
  } lbpStrobes_t;

endpackage

// File: rtl/lbp_ctrl.sv
module lbp_ctrl
  import lbp_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic [1:0]  inMode,
  output lbpStrobes_t strobes,
  output logic        outValid
);

  lbpMode_e modeSel;
  logic     validQ;

  assign modeSel = lbpMode_e'(inMode);

  always_comb begin
    strobes.load      = inValid;
    strobes.upperKeep = (modeSel == MODE_KEEP128);
    strobes.upperZero = (modeSel == MODE_ZERO128);
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

  assign outValid = validQ;

  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R2
  valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

endmodule

// File: rtl/lbp_datapath.sv
module lbp_datapath
  import lbp_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int LANE_BYTES = 16,
  parameter int NUM_LANES  = 2
) (
  input  logic                                    clk,
  input  logic                                    rst,
  input  lbpStrobes_t                             strobes,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0]  inData,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0]  inCtrl,
  output logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0]  outData
);

  localparam int DATA_W = NUM_LANES * LANE_BYTES * BYTE_W;
  localparam int HALF_W = DATA_W / 2;
  localparam int IDX_W  = $clog2(LANE_BYTES);

  logic [DATA_W-1:0] shuffled;
  logic [DATA_W-1:0] resultQ;

  genvar ln, bt;
  generate
    for (ln = 0; ln < NUM_LANES; ln++) begin : g_lane
      logic [BYTE_W-1:0] srcBytes [LANE_BYTES];
      for (bt = 0; bt < LANE_BYTES; bt++) begin : g_src
        assign srcBytes[bt] = inData[(ln*LANE_BYTES + bt)*BYTE_W +: BYTE_W];
      end
      for (bt = 0; bt < LANE_BYTES; bt++) begin : g_dst
        logic [BYTE_W-1:0] ctrlByte;
        assign ctrlByte = inCtrl[(ln*LANE_BYTES + bt)*BYTE_W +: BYTE_W];
        assign shuffled[(ln*LANE_BYTES + bt)*BYTE_W +: BYTE_W] =
          ctrlByte[BYTE_W-1] ? '0 : srcBytes[ctrlByte[IDX_W-1:0]];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      resultQ <= '0;
    end else if (strobes.load) begin
      resultQ[HALF_W-1:0] <= shuffled[HALF_W-1:0];
      if (strobes.upperZero)
        resultQ[DATA_W-1:HALF_W] <= '0;
      else if (!strobes.upperKeep)
        resultQ[DATA_W-1:HALF_W] <= shuffled[DATA_W-1:HALF_W];
    end
  end

  assign outData = resultQ;

  // R3
  zero_force_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && inCtrl[BYTE_W-1]) |=> (outData[BYTE_W-1:0] == '0));

  // R7
  upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.upperKeep) |=> $stable(outData[DATA_W-1:HALF_W]));

  // R8
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (strobes.load && strobes.upperZero) |=> (outData[DATA_W-1:HALF_W] == '0));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(outData));

endmodule

// File: rtl/lane_byte_permuter.sv
module lane_byte_permuter
  import lbp_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int LANE_BYTES = 16,
  parameter int NUM_LANES  = 2
) (
  input  logic                                   clk,
  input  logic                                   rst,
  input  logic                                   inValid,
  input  logic [1:0]                             inMode,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] inData,
  input  logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] inCtrl,
  output logic                                   outValid,
  output logic [NUM_LANES*LANE_BYTES*BYTE_W-1:0] outData
);

  lbpStrobes_t strobes;

  lbp_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inMode   (inMode),
    .strobes  (strobes),
    .outValid (outValid)
  );

  lbp_datapath #(
    .BYTE_W     (BYTE_W),
    .LANE_BYTES (LANE_BYTES),
    .NUM_LANES  (NUM_LANES)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .inData  (inData),
    .inCtrl  (inCtrl),
    .outData (outData)
  );

endmodule

// File: tb/sim_lane_byte_permuter.sv
`timescale 1ns/1ps
module sim_lane_byte_permuter;

  logic         clk = 1'b0;
  logic         rst;
  logic         inValid;
  logic [1:0]   inMode;
  logic [255:0] inData;
  logic [255:0] inCtrl;
  logic         outValid;
  logic [255:0] outData;

  int checks = 0;
  int failures = 0;
  logic [255:0] expData;
  logic         expValid;

  always #2 clk = ~clk;

  lane_byte_permuter u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inMode(inMode),
    .inData(inData), .inCtrl(inCtrl), .outValid(outValid), .outData(outData)
  );

  function automatic logic [255:0] refModel(input logic [255:0] d, input logic [255:0] c,
                                             input logic [1:0] m, input logic [255:0] prev);
    logic [255:0] r;
    r = '0;
    for (int i = 0; i < 32; i++) begin
      int lane;
      int sel;
      logic [7:0] cb;
      lane = i / 16;
      cb = c[i*8 +: 8];
      sel = lane * 16 + (cb % 16);
      if (lane == 1 && m == 2'd0)       r[i*8 +: 8] = prev[i*8 +: 8];
      else if (lane == 1 && m == 2'd1)  r[i*8 +: 8] = 8'h00;
      else if (cb >= 8'h80)             r[i*8 +: 8] = 8'h00;
      else                              r[i*8 +: 8] = d[sel*8 +: 8];
    end
    return r;
  endfunction

  task automatic check(input string tag);
    checks++;
    if (outValid !== expValid) begin
      failures++;
      $display("FAIL R2 outValid actual=%0b expected=%0b", outValid, expValid);
    end
    checks++;
    if (outData !== expData) begin
      failures++;
      $display("FAIL %s outData actual=%h expected=%h", tag, outData, expData);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] m, input logic [255:0] d,
                      input logic [255:0] c, input string tag);
    @(negedge clk);
    inValid = v; inMode = m; inData = d; inCtrl = c;
    @(posedge clk);
    expValid = v;
    if (v) expData = refModel(d, c, m, expData);
    @(negedge clk);
    check(tag);
  endtask

  function automatic logic [255:0] laneData(input int seed);
    logic [255:0] r;
    for (int i = 0; i < 32; i++) r[i*8 +: 8] = 8'((i < 16 ? 8'h10 : 8'hA0) + i + seed);
    return r;
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [255:0] ident, rev, allz, hiBits, rd, rc;
    for (int i = 0; i < 32; i++) begin
      ident[i*8 +: 8]  = 8'(i % 16);
      rev[i*8 +: 8]    = 8'(15 - (i % 16));
      allz[i*8 +: 8]   = 8'h80;
      hiBits[i*8 +: 8] = 8'h70 | 8'((i * 7) % 16);
    end
    rst = 1'b1; inValid = 1'b0; inMode = 2'b10; inData = '0; inCtrl = '0;
    expData = '0; expValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R1");
    rst = 1'b0;

    step(1'b1, 2'b10, laneData(0), ident, "R4 R6 R9 identity");
    step(1'b1, 2'b10, laneData(3), rev, "R4 R6 reversal");
    step(1'b1, 2'b10, laneData(5), allz, "R3 all 0x80");
    step(1'b1, 2'b11, laneData(9), hiBits, "R5 R6 bits 6:4 set");
    step(1'b1, 2'b10, laneData(1), rev, "R6 load upper");
    step(1'b1, 2'b00, laneData(7), ident, "R7 R9 keep upper");
    step(1'b0, 2'b01, laneData(2), allz, "R10 idle hold");
    step(1'b0, 2'b10, laneData(4), rev, "R10 idle hold");
    step(1'b1, 2'b01, laneData(8), rev, "R8 zero upper");
    step(1'b1, 2'b00, laneData(6), allz, "R3 R7 keep zeros");

    for (int n = 0; n < 60; n++) begin
      for (int w = 0; w < 8; w++) begin
        rd[w*32 +: 32] = $urandom;
        rc[w*32 +: 32] = $urandom;
      end
      step(1'($urandom % 4 != 0), 2'($urandom), rd, rc, "R3 R4 R5 R6 R7 R8 R9 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule